// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is the bus-facing side of a small register space. An external I2C controller reaches it at fast-mode rates, and a much faster system clock oversamples the bus. Before any edge or bus condition is decoded, the block passes SCL and SDA through a synchronizer and a stability filter. Two strap pins choose the 7-bit device address from a fixed table of four entries. The entries are not consecutive, so the address cannot be formed as a base plus an offset.

The block holds an 8-bit register pointer. A write transaction loads the pointer from its first byte and then stores every following byte at the pointer, advancing it by one each time. A read can be preceded by a pointer-setting write phase and a repeated START. A read can also begin with address+R alone, in which case it continues from wherever the pointer currently stands. On the register side there are single-cycle write and read strobes, shared by one address bus. There is no back-pressure: a write strobe commits in the cycle it is high, and the read data must be valid combinationally in the cycle the read strobe is high. SDA is never driven high. The block only asserts a pull-down request, and releasing that request leaves the line floating.

Top module: `i2c_strap_regslave`

## Requirements
- R1: Strap value 0 gives address 0x42, 1 gives 0x43, 2 gives 0x45 and 3 gives 0x54. An address byte whose upper seven bits match the selected entry is ACKed (SDA pulled low in the ninth clock).
- R2: An address that does not match is NACKed. After it the block ignores the bus until the next START or STOP: no strobe, no pull-down, and the pointer is unchanged.
- R3: In a write, the byte after the address is the pointer. Each later byte is ACKed, issued as a write strobe at the current pointer, and the pointer then increments.
- R4: After a pointer phase and a repeated START, address+R returns the register at the pointer and then the registers above it. Each byte is sent MSB first, and each read strobe advances the pointer.
- R5: A controller ACK after a read byte fetches the next register. A NACK ends the read, with no further read strobe and SDA released.
- R6: A read that opens with address+R starts at the current pointer. After a read, the pointer stands one above the last byte fetched.
- R7: SCL or SDA pulses of 30 ns or less (3 system clocks) have no effect on received data and are not seen as START or STOP.
- R8: SDA is only ever pulled low. The pull-down is released in the cycle after a STOP is detected.
- R9: A START or STOP in the middle of a byte discards that byte (no write strobe). After a START, the block goes back to address reception.
- R10: After reset the pull-down and both strobes are inactive.
- R11: The pointer wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_sel | input | 2 | Device address select straps |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_addr | output | 8 | Register pointer / strobe address |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data, valid in the reg_rd cycle |

## Verification
Each bus line passes through two synchronizer flops and then FILT_CYC (6) cycles of stability, and one edge-detect register follows. As a result, a pull-down request or strobe appears about nine system cycles after the SCL edge that triggers it. The ACK or data bit is set up after a falling SCL edge, and the controller samples it in the middle of the following high phase, a full quarter-bit (32 cycles) later. Every check of SDA is taken at that midpoint on a falling system clock edge. Register contents and strobe counts are checked only after the STOP that closes a transaction, when every strobe has long since landed.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } st_e;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYC - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_f,
  input  logic              sda_f,
  output logic              sda_pull,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  st_e               st;
  logic              scl_q, sda_q;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic [PTR_W-1:0]  ptr;
  logic              rw, mack;

  logic start_det, stop_det, scl_rise, scl_fall, byte_in;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign byte_in   = scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt   <= '0;
      shreg <= '0;
      ptr   <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_det) begin
        st  <= ST_ADDR;
        cnt <= '0;
      end else if (stop_det) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_f};
              cnt   <= cnt + 4'd1;
            end else if (byte_in) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  rw <= shreg[0];
                  st <= ST_AACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_PTR) begin
                ptr <= shreg[PTR_W-1:0];
                st  <= ST_PACK;
              end else begin
                ptr <= ptr + 1'b1;
                st  <= ST_WACK;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (rw) begin
              shreg <= reg_rdata;
              ptr   <= ptr + 1'b1;
              cnt   <= '0;
              st    <= ST_RDAT;
            end else begin
              st <= ST_PTR;
            end
          end
          ST_PACK, ST_WACK: if (scl_fall) st <= ST_WDAT;
          ST_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= ST_RACK;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              cnt   <= cnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              if (mack) begin
                shreg <= reg_rdata;
                ptr   <= ptr + 1'b1;
                cnt   <= '0;
                st    <= ST_RDAT;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_wr    = (st == ST_WDAT) && byte_in;
  assign reg_rd    = scl_fall && (((st == ST_AACK) && rw) || ((st == ST_RACK) && mack));
  assign reg_addr  = ptr;
  assign reg_wdata = shreg;
  assign sda_pull  = (st == ST_AACK) || (st == ST_PACK) || (st == ST_WACK) ||
                     ((st == ST_RDAT) && !shreg[7]);

  assert_ptr_step_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));
  assert_ptr_step_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> (!reg_wr && !reg_rd && !sda_pull));
  assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
  assert_start_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR) && !sda_pull);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: rtl/i2c_strap_regslave.sv
module i2c_strap_regslave #(
  parameter int          FILT_CYC   = 6,
  parameter logic [27:0] ADDR_TABLE = {7'h54, 7'h45, 7'h43, 7'h42}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, filt;
  logic [6:0]       dev_addr;

  assign raw      = {sda_in, scl_in};
  assign dev_addr = ADDR_TABLE[strap_sel*7 +: 7];

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_CYC(FILT_CYC)) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  i2cs_fsm #(.PTR_W(8)) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .scl_f    (filt[0]),
    .sda_f    (filt[1]),
    .sda_pull (sda_pull),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/i2c_strap_regslave_tb_top.sv
module i2c_strap_regslave_tb_top;
  localparam int Q = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] strap_sel = 2'd0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int n_cmp = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus   = sda_m & ~sda_pull;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  i2c_strap_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask

  task automatic put_bit(input logic b, input bit g, output logic smp);
    sda_m = b; wq(); scl_m = 1;
    repeat (8) @(negedge clk);
    if (g) begin
      scl_m = 0; repeat (3) @(negedge clk); scl_m = 1;
      repeat (5) @(negedge clk);
      sda_m = ~b; repeat (3) @(negedge clk); sda_m = b;
      repeat (Q - 19) @(negedge clk);
    end else begin
      repeat (Q - 8) @(negedge clk);
    end
    smp = sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit g, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(v[i], g, s);
    put_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit nack);
    logic s;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, 1'b0, s); v[i] = s; end
    put_bit(nack, 1'b0, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d, ptr_exp;
    logic [6:0] tab [4];
    int w0, r0;
    tab[0] = 7'h42; tab[1] = 7'h43; tab[2] = 7'h45; tab[3] = 7'h54;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'hA5; expm[i] = 8'(i) ^ 8'hA5; end
    repeat (3) @(negedge clk);
    check("R10 pull after reset", sda_pull, 0);
    check("R10 strobes after reset", {reg_wr, reg_rd}, 0);
    rst_n = 1; repeat (20) @(negedge clk);

    // R1 / R2: every strap against every table address
    for (int s = 0; s < 4; s++) begin
      strap_sel = 2'(s); repeat (4) @(negedge clk);
      for (int a = 0; a < 4; a++) begin
        bus_start(); send_byte({tab[a], 1'b0}, 1'b0, ack); bus_stop();
        check(a == s ? "R1 ack own address" : "R2 nack foreign address", ack, (a == s));
      end
    end
    check("R2 no strobe during sweep", wr_cnt + rd_cnt, 0);
    strap_sel = 2'd2; repeat (4) @(negedge clk);

    // R3 write three bytes from 0x10
    bus_start(); send_byte({tab[2], 1'b0}, 0, ack); check("R3 addr ack", ack, 1);
    send_byte(8'h10, 0, ack); check("R3 ptr ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(8'h11 * (i + 1)), 0, ack); check("R3 data ack", ack, 1);
      expm[8'h10 + i] = 8'(8'h11 * (i + 1));
    end
    bus_stop();
    for (int i = 0; i < 3; i++) check("R3 stored byte", mem[8'h10 + i], expm[8'h10 + i]);

    // R4 / R5 pointed read of four bytes
    r0 = rd_cnt;
    bus_start(); send_byte({tab[2], 1'b0}, 0, ack); send_byte(8'h10, 0, ack);
    bus_start(); send_byte({tab[2], 1'b1}, 0, ack); check("R4 read addr ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      get_byte(d, i == 3); check("R4 pointed read data", d, expm[8'h10 + i]);
    end
    check("R5 pull released after nack", sda_pull, 0);
    bus_stop();
    check("R5 read strobes match bytes", rd_cnt - r0, 4);
    ptr_exp = 8'h14;

    // R6 read without pointer phase
    bus_start(); send_byte({tab[2], 1'b1}, 0, ack);
    for (int i = 0; i < 2; i++) begin
      get_byte(d, i == 1); check("R6 current-pointer read", d, expm[ptr_exp]); ptr_exp++;
    end
    bus_stop();

    // R2 foreign write must not move pointer nor store
    w0 = wr_cnt;
    bus_start(); send_byte({7'h43, 1'b0}, 0, ack); check("R2 foreign nack", ack, 0);
    send_byte(8'h20, 0, ack); check("R2 ignored ptr byte", ack, 0);
    send_byte(8'h99, 0, ack); bus_stop();
    check("R2 no write strobe", wr_cnt - w0, 0);
    bus_start(); send_byte({tab[2], 1'b1}, 0, ack); get_byte(d, 1); bus_stop();
    check("R2 pointer untouched", d, expm[ptr_exp]); ptr_exp++;

    // R11 wrap
    bus_start(); send_byte({tab[2], 1'b0}, 0, ack); send_byte(8'hFF, 0, ack);
    send_byte(8'h3C, 0, ack); send_byte(8'hC3, 0, ack); bus_stop();
    expm[8'hFF] = 8'h3C; expm[8'h00] = 8'hC3;
    check("R11 byte at 0xFF", mem[8'hFF], 8'h3C);
    check("R11 byte wrapped to 0x00", mem[8'h00], 8'hC3);
    bus_start(); send_byte({tab[2], 1'b1}, 0, ack); get_byte(d, 1); bus_stop();
    check("R11 pointer after wrap", d, expm[8'h01]);

    // R7 glitches on every data bit
    bus_start(); send_byte({tab[2], 1'b0}, 1, ack); check("R7 addr ack with glitches", ack, 1);
    send_byte(8'h30, 1, ack); send_byte(8'h5A, 1, ack); send_byte(8'hB4, 1, ack); bus_stop();
    expm[8'h30] = 8'h5A; expm[8'h31] = 8'hB4;
    check("R7 glitched byte 0", mem[8'h30], 8'h5A);
    check("R7 glitched byte 1", mem[8'h31], 8'hB4);

    // R9 repeated START mid-byte
    w0 = wr_cnt;
    bus_start(); send_byte({tab[2], 1'b0}, 0, ack); send_byte(8'h40, 0, ack);
    for (int i = 0; i < 4; i++) begin logic s; put_bit(1'b0, 0, s); end
    bus_start(); send_byte({tab[2], 1'b0}, 0, ack); check("R9 address after restart", ack, 1);
    send_byte(8'h41, 0, ack); send_byte(8'h77, 0, ack); bus_stop();
    expm[8'h41] = 8'h77;
    check("R9 partial byte dropped", mem[8'h40], expm[8'h40]);
    check("R9 following write lands", mem[8'h41], 8'h77);
    check("R9 single write strobe", wr_cnt - w0, 1);

    // R9 / R8 STOP mid-byte
    w0 = wr_cnt;
    bus_start(); send_byte({tab[2], 1'b0}, 0, ack); send_byte(8'h50, 0, ack);
    for (int i = 0; i < 3; i++) begin logic s; put_bit(1'b1, 0, s); end
    bus_stop();
    check("R8 released after stop", sda_pull, 0);
    check("R9 no strobe on stop abort", wr_cnt - w0, 0);
    bus_start(); send_byte({tab[2], 1'b1}, 0, ack); get_byte(d, 1); bus_stop();
    check("R6 read resumes at set pointer", d, expm[8'h50]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule